// File: doc/BRIEF.md
# Single-Port Operand Fetch Sequencer

This block fetches the register operands for one instruction of a multi-cycle 32-bit RISC datapath. The register file behind it has a single read port. The sequencer takes a decoded instruction word with a start strobe and works out which of the two source operands it needs. It then reads only those operands that cannot be supplied another way. An operand naming register zero becomes a constant zero. An operand that the forwarding inputs mark as available is taken from the forwarding bus. Every remaining operand costs one read-port cycle, the first source before the second. The results land in operand registers A and B. A one-cycle done strobe then tells the execute stage to begin.

Operand-fetch latency therefore ranges from zero to two port accesses, depending on the instruction class and the operand values. The block reports the number of accesses it used alongside done. The register file presents read data in the same cycle as the address; the sequencer captures that data at the closing clock edge.

Top module: `opf_seq_top`

## Requirements
- R1: Opcode 0 (bits 31:26, register-register) uses the first source (bits 25:21) and the second source (bits 20:16). Each one still needing a read costs one port access, the first source before the second. A receives the first source and B receives the second.
- R2: Opcode 0x23 (load) uses only the first source: at most one access. B is 0.
- R3: Opcode 0x2B (store) uses both sources with the same ordering as R1, so it takes up to two accesses.
- R4: Opcodes 0x08 to 0x0F (immediate operations) use only the first source: at most one access. B is 0.
- R5: An operand naming register 0 is loaded as 0 with no access, and address 0 never appears on the read port while the read enable is high.
- R6: When a forwarding valid input is high in the start cycle for a used, non-zero operand, its forwarding data from that cycle is loaded and no access is spent on it.
- R7: With no access needed, done is high in the first cycle after the start cycle.
- R8: While done is high, the access-count output equals the number of cycles in which the read enable was high during that fetch.
- R9: done is high for exactly one cycle, n+1 cycles after the start cycle, where n is the access count. A and B hold their values afterwards.
- R10: A start while busy is high is ignored. The running fetch finishes with its own operands and accesses.
- R11: Synchronous active-high reset clears A, B, done, busy and the read enable.
- R12: Any other opcode uses no source: zero accesses, A and B both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin fetch for `instr` (accepted only when idle) |
| instr | input | 32 | Instruction word |
| fwd_a_vld | input | 1 | First-source value available on `fwd_a_data` |
| fwd_a_data | input | 32 | Forwarded first-source value |
| fwd_b_vld | input | 1 | Second-source value available on `fwd_b_data` |
| fwd_b_data | input | 32 | Forwarded second-source value |
| rf_ren | output | 1 | Read-port enable |
| rf_raddr | output | 5 | Read-port register address |
| rf_rdata | input | 32 | Read data, valid in the cycle the address is driven |
| opnd_a | output | 32 | Operand register A |
| opnd_b | output | 32 | Operand register B |
| done | output | 1 | Operands ready (one-cycle strobe) |
| busy | output | 1 | Fetch in progress |
| nreads | output | 2 | Port accesses used by the last fetch |

## Verification
Each fetch is started on a falling edge, and the clock edge that follows is the start edge. The bench counts falling edges after that start edge. It expects done on exactly the (n+1)-th falling edge, where n is computed from the opcode, register-zero and forwarding flags. It checks A, B and the access count on that same falling edge, and checks on the next falling edge that done has dropped. The read port is sampled on every intermediate falling edge, so both the order of the addresses and how many there are get compared with the expected list. The forwarding data is changed right after the start edge, which proves it was captured in the start cycle.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int REG_W   = 5;
  localparam int OP_LSB  = 26;
  localparam int SA_LSB  = 21;
  localparam int SB_LSB  = 16;

  localparam logic [OP_W-1:0] OP_RR    = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_IMM_LO = 6'h08;
  localparam logic [OP_W-1:0] OP_IMM_HI = 6'h0F;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RDA  = 2'd1,
    ST_RDB  = 2'd2,
    ST_FIN  = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic use_a;
    logic use_b;
  } src_use_t;
endpackage

// File: rtl/opf_decode.sv
module opf_decode
  import opf_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output src_use_t        uses
);
  always_comb begin
    uses = '0;
    if (opcode == OP_RR || opcode == OP_STORE) begin
      uses.use_a = 1'b1;
      uses.use_b = 1'b1;
    end else if (opcode == OP_LOAD ||
                 (opcode >= OP_IMM_LO && opcode <= OP_IMM_HI)) begin
      uses.use_a = 1'b1;
    end
  end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             need_a,
  input  logic             need_b,
  output seq_state_t       state,
  output logic [CNT_W-1:0] count
);
  logic need_b_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      count    <= '0;
      need_b_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          count    <= '0;
          need_b_q <= need_b;
          if (need_a)      state <= ST_RDA;
          else if (need_b) state <= ST_RDB;
          else             state <= ST_FIN;
        end
        ST_RDA: begin
          count <= count + 1'b1;
          state <= need_b_q ? ST_RDB : ST_FIN;
        end
        ST_RDB: begin
          count <= count + 1'b1;
          state <= ST_FIN;
        end
        ST_FIN: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opf_seq_top.sv
module opf_seq_top
  import opf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [INSTR_W-1:0] instr,
  input  logic              fwd_a_vld,
  input  logic [DATA_W-1:0] fwd_a_data,
  input  logic              fwd_b_vld,
  input  logic [DATA_W-1:0] fwd_b_data,
  output logic              rf_ren,
  output logic [REG_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              done,
  output logic              busy,
  output logic [CNT_W-1:0]  nreads
);
  logic [OP_W-1:0]  opcode;
  logic [REG_W-1:0] src_a, src_b, src_a_q, src_b_q;
  src_use_t         uses;
  seq_state_t       state;
  logic             accept, zero_a, zero_b, need_a, need_b;

  assign opcode = instr[OP_LSB +: OP_W];
  assign src_a  = instr[SA_LSB +: REG_W];
  assign src_b  = instr[SB_LSB +: REG_W];

  opf_decode u_dec (.opcode(opcode), .uses(uses));

  assign zero_a = (src_a == '0);
  assign zero_b = (src_b == '0);
  assign need_a = uses.use_a && !zero_a && !fwd_a_vld;
  assign need_b = uses.use_b && !zero_b && !fwd_b_vld;
  assign accept = start && (state == ST_IDLE);

  opf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .accept(accept),
    .need_a(need_a), .need_b(need_b),
    .state(state), .count(nreads)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      opnd_a  <= '0;
      opnd_b  <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
    end else begin
      if (accept) begin
        src_a_q <= src_a;
        src_b_q <= src_b;
        opnd_a  <= (uses.use_a && !zero_a && fwd_a_vld) ? fwd_a_data : '0;
        opnd_b  <= (uses.use_b && !zero_b && fwd_b_vld) ? fwd_b_data : '0;
      end
      if (state == ST_RDA) opnd_a <= rf_rdata;
      if (state == ST_RDB) opnd_b <= rf_rdata;
    end
  end

  assign rf_ren   = (state == ST_RDA) || (state == ST_RDB);
  assign rf_raddr = (state == ST_RDB) ? src_b_q : src_a_q;
  assign done     = (state == ST_FIN);
  assign busy     = (state != ST_IDLE);
endmodule

// File: rtl/opf_seq_chk.sv
module opf_seq_chk #(
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             rf_ren,
  input logic [4:0]       rf_raddr,
  input logic             done,
  input logic             busy,
  input logic [CNT_W-1:0] nreads
);
  logic [CNT_W:0] seen;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) seen <= '0;
    else if (rf_ren)             seen <= seen + 1'b1;
  end

  // R5
  zero_never_read_chk: assert property (@(posedge clk) disable iff (rst)
    rf_ren |-> rf_raddr != 5'd0);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  read_then_done_chk: assert property (@(posedge clk) disable iff (rst)
    rf_ren |=> (rf_ren || done));

  // R8
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ({1'b0, nreads} == seen));

  // R10
  idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !busy);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!busy && !done && !rf_ren));
endmodule

bind opf_seq_top opf_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .rf_ren(rf_ren),
  .rf_raddr(rf_raddr), .done(done), .busy(busy), .nreads(nreads)
);

// File: tb/sim_opf_seq_top.sv
module sim_opf_seq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] instr = '0;
  logic        fwd_a_vld = 1'b0, fwd_b_vld = 1'b0;
  logic [31:0] fwd_a_data = '0, fwd_b_data = '0;
  logic        rf_ren, done, busy;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata, opnd_a, opnd_b;
  logic [1:0]  nreads;
  int checks = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  function automatic logic [31:0] regval(input logic [4:0] r);
    return (r == 5'd0) ? 32'hDEADBEEF : (32'h5A000000 ^ ({27'd0, r} * 32'h00010203) ^ {27'd0, r});
  endfunction

  assign rf_rdata = rf_ren ? regval(rf_raddr) : 32'h0;

  opf_seq_top u0 (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .fwd_a_vld(fwd_a_vld), .fwd_a_data(fwd_a_data),
    .fwd_b_vld(fwd_b_vld), .fwd_b_data(fwd_b_data),
    .rf_ren(rf_ren), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .done(done), .busy(busy), .nreads(nreads)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic string tag_of(input logic [5:0] op);
    if (op == 6'h00) return "R1";
    if (op == 6'h23) return "R2";
    if (op == 6'h2B) return "R3";
    if (op >= 6'h08 && op <= 6'h0F) return "R4";
    return "R12";
  endfunction

  // One fetch; intr=1 pulses a conflicting start while busy (R10).
  task automatic run(input logic [5:0] op, input logic [4:0] ra, input logic [4:0] rb,
                     input bit fa, input bit fb, input bit intr);
    bit ua, ub, na, nb;
    int n, k, nseen;
    logic [31:0] ea, eb, fda, fdb;
    logic [4:0] exp_addr[2];
    logic [4:0] got_addr[4];
    string tg;
    tg = tag_of(op);
    ua = (op == 6'h00) || (op == 6'h2B) || (op == 6'h23) || (op >= 6'h08 && op <= 6'h0F);
    ub = (op == 6'h00) || (op == 6'h2B);
    na = ua && ra != 0 && !fa;
    nb = ub && rb != 0 && !fb;
    fda = 32'hF0A00000 | {27'd0, ra};
    fdb = 32'hF0B00000 | {27'd0, rb};
    ea = (!ua || ra == 0) ? 32'h0 : (fa ? fda : regval(ra));
    eb = (!ub || rb == 0) ? 32'h0 : (fb ? fdb : regval(rb));
    n = 0;
    if (na) begin exp_addr[n] = ra; n++; end
    if (nb) begin exp_addr[n] = rb; n++; end
    @(negedge clk);
    instr = {op, ra, rb, 16'h1234};
    fwd_a_vld = fa; fwd_b_vld = fb; fwd_a_data = fda; fwd_b_data = fdb;
    start = 1'b1;
    @(posedge clk);
    k = 0; nseen = 0;
    while (k < 6) begin
      @(negedge clk);
      start = 1'b0;
      fwd_a_data = 32'hBAD0BAD0; fwd_b_data = 32'hBAD1BAD1;
      k++;
      if (intr && k == 1) begin
        instr = {6'h23, 5'd9, 5'd9, 16'h0};
        fwd_a_vld = 1'b0; fwd_b_vld = 1'b0;
        start = 1'b1;
      end
      if (rf_ren) begin
        if (nseen < 4) got_addr[nseen] = rf_raddr;
        nseen++;
      end
      if (done) break;
    end
    start = 1'b0;
    // R9 / R7 timing: done on edge n+1 after start
    chk(k == n + 1, (n == 0) ? "R7" : "R9", k, n + 1);
    chk(nseen == n, "R5 access count", nseen, n);
    for (int i = 0; i < n && i < nseen; i++)
      chk(got_addr[i] == exp_addr[i], {tg, " read order"}, {27'd0, got_addr[i]}, {27'd0, exp_addr[i]});
    chk(opnd_a == ea, {tg, (fa ? " R6" : ""), " A"}, opnd_a, ea);
    chk(opnd_b == eb, {tg, (fb ? " R6" : ""), " B"}, opnd_b, eb);
    chk(nreads == n[1:0], "R8", {30'd0, nreads}, n);
    @(negedge clk);
    chk(!done, "R9 pulse", {31'd0, done}, 0);
    chk(opnd_a == ea && opnd_b == eb, "R9 hold", opnd_a, ea);
    if (intr) chk(!busy, "R10 start ignored", {31'd0, busy}, 0);
  endtask

  initial begin
    logic [5:0] ops[13];
    logic [4:0] regs[4];
    ops = '{6'h00, 6'h23, 6'h2B, 6'h08, 6'h09, 6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h04, 6'h3F};
    regs = '{5'd0, 5'd1, 5'd7, 5'd31};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(opnd_a == 0 && opnd_b == 0, "R11 operands", opnd_a, 0);
    chk(!done && !busy && !rf_ren, "R11 control", {29'd0, done, busy, rf_ren}, 0);
    rst = 1'b0;
    for (int o = 0; o < 13; o++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          for (int f = 0; f < 4; f++)
            run(ops[o], regs[i], regs[j], f[0], f[1], 1'b0);
    // R10: conflicting start during store and register-register fetches
    run(6'h2B, 5'd3, 5'd5, 1'b0, 1'b0, 1'b1);
    run(6'h00, 5'd12, 5'd30, 1'b0, 1'b0, 1'b1);
    run(6'h2B, 5'd0, 5'd6, 1'b0, 1'b0, 1'b0);
    // R11: reset mid-fetch
    @(negedge clk);
    instr = {6'h00, 5'd4, 5'd5, 16'h0}; fwd_a_vld = 0; fwd_b_vld = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk(opnd_a == 0 && opnd_b == 0 && !busy && !done, "R11 mid-fetch", opnd_a, 0);
    rst = 1'b0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule